// File: doc/BRIEF.md
# Tag-Only Reservation Station Pool

This block holds instructions that have been renamed and dispatched but are still waiting for their source operands. The entries are grouped by functional unit class, and each class has a small, fixed number of slots. An entry keeps control information only: a busy flag, the opcode, the destination physical tag with a flag that says whether a destination exists, two source physical tags, each with its own ready bit, and the reorder-buffer index of the instruction. Operand values are never stored here. The unit reads them later from the physical register file, using the tags this block hands out.

Ready bits have two sources. The first is dispatch, where the rename map supplies them. The second is a completion broadcast that carries only a physical tag. Every source in every busy entry that matches the broadcast tag becomes ready. When both sources of an entry are ready, the entry is offered to its class's issue port, and it is released at the same clock edge. A rollback input removes every entry that is younger than a given reorder-buffer index. Age is measured from the current reorder-buffer head, so the index may wrap.

Top module: `rs_pool`

## Requirements
- R1: After reset no entry is busy, every `iss_valid` bit is 0, and a dispatch to any class does not stall.
- R2: A dispatch with `disp_valid`=1 is written into the lowest-numbered free slot of the class given by `disp_fu`. If that class has no free slot, `disp_stall` is 1 in the same cycle and the dispatch is dropped.
- R3: The ready bit of each source is taken from `disp_src1_rdy` or `disp_src2_rdy` when the entry is written.
- R4: While `cdb_valid`=1, every source of every busy entry whose tag equals `cdb_tag` becomes ready at that clock edge. While `cdb_valid`=0, `cdb_tag` has no effect.
- R5: A broadcast in the same cycle as a dispatch also marks as ready the matching sources of the entry being written.
- R6: `iss_valid[c]` is 1 in the first cycle in which a busy entry of class c has both sources ready. In that cycle `iss_op`, `iss_dst`, `iss_src1` and `iss_src2` carry that entry's fields. When several entries of a class are ready, the lowest slot is issued first.
- R7: An entry that issues is freed at the end of its issue cycle, and a dispatch in the next cycle may take its slot.
- R8: An entry dispatched with `disp_has_dst`=0 (for example a store) issues with `iss_has_dst`=0 and `iss_dst` all zeros.
- R9: While `flush_valid`=1, every busy entry whose age is greater than the age of `flush_rob` is cleared at that edge, and it does not issue in that cycle. Age is the index minus `rob_head`, modulo 2^ROB_W. Entries of the same age or older are kept.
- R10: A dispatch in a cycle with `flush_valid`=1 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_fu | input | FU_W | Functional unit class of the dispatched instruction |
| disp_op | input | OP_W | Opcode |
| disp_has_dst | input | 1 | Instruction writes a destination register |
| disp_dst | input | TAG_W | Destination physical tag |
| disp_src1 | input | TAG_W | First source physical tag |
| disp_src1_rdy | input | 1 | First source is ready according to the rename map |
| disp_src2 | input | TAG_W | Second source physical tag |
| disp_src2_rdy | input | 1 | Second source is ready according to the rename map |
| disp_rob | input | ROB_W | Reorder-buffer index of the instruction |
| disp_stall | output | 1 | No free slot in the requested class |
| cdb_valid | input | 1 | Completion broadcast is valid |
| cdb_tag | input | TAG_W | Physical tag that completed |
| rob_head | input | ROB_W | Index of the oldest reorder-buffer entry |
| flush_valid | input | 1 | Roll back younger instructions |
| flush_rob | input | ROB_W | Rollback target; entries younger than it are removed |
| iss_valid | output | NUM_FU | Issue valid, one bit per class |
| iss_op | output | NUM_FU x OP_W | Opcode being issued |
| iss_has_dst | output | NUM_FU | Issued instruction writes a destination |
| iss_dst | output | NUM_FU x TAG_W | Destination tag being issued (zero when there is none) |
| iss_src1 | output | NUM_FU x TAG_W | First source tag being issued |
| iss_src2 | output | NUM_FU x TAG_W | Second source tag being issued |

## Verification
Three pairs of functions can fall in the same cycle. The first pair is a broadcast and the writing of an entry whose source matches the broadcast tag. The bench drives both in one cycle and expects the entry to issue in the very next cycle. The second pair is a rollback and an entry that is ready to issue in that cycle. The bench judges this by seeing `iss_valid` stay low in the rollback cycle and afterwards. The third pair is a rollback and a dispatch in the same cycle, where the dispatched entry must never issue.

// File: rtl/rs_pkg.sv
package rs_pkg;

  localparam int TAG_W = 6;
  localparam int OP_W  = 5;
  localparam int ROB_W = 4;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic             has_dst;
    logic [TAG_W-1:0] dst;
    logic [TAG_W-1:0] src1;
    logic             rdy1;
    logic [TAG_W-1:0] src2;
    logic             rdy2;
    logic [ROB_W-1:0] rob;
  } rs_fields_t;

  // distance of a reorder-buffer index from the head, wrapping
  function automatic logic [ROB_W-1:0] rob_age(input logic [ROB_W-1:0] idx,
                                               input logic [ROB_W-1:0] head);
    return idx - head;
  endfunction

  function automatic logic is_younger(input logic [ROB_W-1:0] idx,
                                      input logic [ROB_W-1:0] tgt,
                                      input logic [ROB_W-1:0] head);
    return rob_age(idx, head) > rob_age(tgt, head);
  endfunction

  function automatic logic tag_hit(input logic             bvalid,
                                   input logic [TAG_W-1:0] btag,
                                   input logic [TAG_W-1:0] stag);
    return bvalid && (btag == stag);
  endfunction

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
    any = taken;
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  rs_fields_t       wr_f,
  input  logic             cdb_valid,
  input  logic [TAG_W-1:0] cdb_tag,
  input  logic             clr,
  output logic             busy,
  output rs_fields_t       f,
  output logic             req
);
  logic wr_wake1, wr_wake2, hold_wake1, hold_wake2;

  assign wr_wake1   = tag_hit(cdb_valid, cdb_tag, wr_f.src1);
  assign wr_wake2   = tag_hit(cdb_valid, cdb_tag, wr_f.src2);
  assign hold_wake1 = tag_hit(cdb_valid, cdb_tag, f.src1);
  assign hold_wake2 = tag_hit(cdb_valid, cdb_tag, f.src2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      f    <= '0;
    end else if (wr_en) begin
      busy   <= 1'b1;
      f      <= wr_f;
      f.rdy1 <= wr_f.rdy1 | wr_wake1;
      f.rdy2 <= wr_f.rdy2 | wr_wake2;
    end else if (clr) begin
      busy <= 1'b0;
    end else begin
      if (hold_wake1) f.rdy1 <= 1'b1;
      if (hold_wake2) f.rdy2 <= 1'b1;
    end
  end

  assign req = busy && f.rdy1 && f.rdy2;
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int NUM_FU = 4,
  parameter int SLOTS  = 2,
  localparam int FU_W  = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          disp_valid,
  input  logic [FU_W-1:0]               disp_fu,
  input  logic [OP_W-1:0]               disp_op,
  input  logic                          disp_has_dst,
  input  logic [TAG_W-1:0]              disp_dst,
  input  logic [TAG_W-1:0]              disp_src1,
  input  logic                          disp_src1_rdy,
  input  logic [TAG_W-1:0]              disp_src2,
  input  logic                          disp_src2_rdy,
  input  logic [ROB_W-1:0]              disp_rob,
  output logic                          disp_stall,
  input  logic                          cdb_valid,
  input  logic [TAG_W-1:0]              cdb_tag,
  input  logic [ROB_W-1:0]              rob_head,
  input  logic                          flush_valid,
  input  logic [ROB_W-1:0]              flush_rob,
  output logic [NUM_FU-1:0]             iss_valid,
  output logic [NUM_FU-1:0][OP_W-1:0]   iss_op,
  output logic [NUM_FU-1:0]             iss_has_dst,
  output logic [NUM_FU-1:0][TAG_W-1:0]  iss_dst,
  output logic [NUM_FU-1:0][TAG_W-1:0]  iss_src1,
  output logic [NUM_FU-1:0][TAG_W-1:0]  iss_src2
);
  localparam int NE = NUM_FU * SLOTS;

  // named internal events, visible to the bound checker
  logic [NE-1:0]            ent_busy;
  logic [NE-1:0]            ent_req;
  logic [NE-1:0]            ent_kill;
  logic [NE-1:0]            ent_gnt;
  logic [NE-1:0]            ent_free_gnt;
  logic [NE-1:0]            ent_wr;
  logic [NE-1:0]            ent_clr;
  logic [NE-1:0]            ent_rdy1;
  logic [NE-1:0]            ent_rdy2;
  logic [NE-1:0][TAG_W-1:0] ent_src1;
  logic [NE-1:0][TAG_W-1:0] ent_src2;
  logic [NUM_FU-1:0]        class_free;
  logic                     disp_ok;
  logic                     sel_free;
  rs_fields_t               ent_f [NE];
  rs_fields_t               disp_f;

  always_comb begin
    disp_f         = '0;
    disp_f.op      = disp_op;
    disp_f.has_dst = disp_has_dst;
    disp_f.dst     = disp_has_dst ? disp_dst : '0;
    disp_f.src1    = disp_src1;
    disp_f.rdy1    = disp_src1_rdy;
    disp_f.src2    = disp_src2;
    disp_f.rdy2    = disp_src2_rdy;
    disp_f.rob     = disp_rob;
  end

  always_comb begin
    sel_free = 1'b0;
    for (int c = 0; c < NUM_FU; c++) begin
      if (disp_fu == FU_W'(c)) sel_free = class_free[c];
    end
  end

  assign disp_stall = disp_valid && !sel_free;
  assign disp_ok    = disp_valid && !flush_valid && sel_free;

  for (genvar c = 0; c < NUM_FU; c++) begin : g_class
    rs_pick #(.N(SLOTS)) u_free_pick (
      .req (~ent_busy[c*SLOTS +: SLOTS]),
      .gnt (ent_free_gnt[c*SLOTS +: SLOTS]),
      .any (class_free[c])
    );

    rs_pick #(.N(SLOTS)) u_issue_pick (
      .req (ent_req[c*SLOTS +: SLOTS] & ~ent_kill[c*SLOTS +: SLOTS]),
      .gnt (ent_gnt[c*SLOTS +: SLOTS]),
      .any (iss_valid[c])
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int E = c * SLOTS + s;

      assign ent_wr[E]   = disp_ok && (disp_fu == FU_W'(c)) && ent_free_gnt[E];
      assign ent_kill[E] = flush_valid && ent_busy[E]
                           && is_younger(ent_f[E].rob, flush_rob, rob_head);
      assign ent_clr[E]  = ent_gnt[E] || ent_kill[E];
      assign ent_rdy1[E] = ent_f[E].rdy1;
      assign ent_rdy2[E] = ent_f[E].rdy2;
      assign ent_src1[E] = ent_f[E].src1;
      assign ent_src2[E] = ent_f[E].src2;

      rs_entry u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ent_wr[E]),
        .wr_f      (disp_f),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .clr       (ent_clr[E]),
        .busy      (ent_busy[E]),
        .f         (ent_f[E]),
        .req       (ent_req[E])
      );
    end
  end

  // and-or issue mux, grant is one-hot per class
  always_comb begin
    iss_op      = '0;
    iss_has_dst = '0;
    iss_dst     = '0;
    iss_src1    = '0;
    iss_src2    = '0;
    for (int c = 0; c < NUM_FU; c++) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (ent_gnt[c*SLOTS+s]) begin
          iss_op[c]      = ent_f[c*SLOTS+s].op;
          iss_has_dst[c] = ent_f[c*SLOTS+s].has_dst;
          iss_dst[c]     = ent_f[c*SLOTS+s].has_dst ? ent_f[c*SLOTS+s].dst : '0;
          iss_src1[c]    = ent_f[c*SLOTS+s].src1;
          iss_src2[c]    = ent_f[c*SLOTS+s].src2;
        end
      end
    end
  end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk
  import rs_pkg::*;
#(
  parameter int NUM_FU = 4,
  parameter int SLOTS  = 2,
  localparam int NE    = NUM_FU * SLOTS
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cdb_valid,
  input logic [TAG_W-1:0]              cdb_tag,
  input logic                          disp_valid,
  input logic                          disp_stall,
  input logic [NE-1:0]                 ent_busy,
  input logic [NE-1:0]                 ent_gnt,
  input logic [NE-1:0]                 ent_kill,
  input logic [NE-1:0]                 ent_wr,
  input logic [NE-1:0]                 ent_rdy1,
  input logic [NE-1:0]                 ent_rdy2,
  input logic [NE-1:0][TAG_W-1:0]      ent_src1,
  input logic [NE-1:0][TAG_W-1:0]      ent_src2,
  input logic [NUM_FU-1:0]             iss_valid,
  input logic [NUM_FU-1:0]             iss_has_dst,
  input logic [NUM_FU-1:0][TAG_W-1:0]  iss_dst
);
  assert_stall_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stall |-> disp_valid);

  for (genvar e = 0; e < NE; e++) begin : g_ent
    assert_write_to_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ent_wr[e] |-> !ent_busy[e]);

    assert_wake_src1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && ent_busy[e] && !ent_gnt[e] && !ent_kill[e] && ent_src1[e] == cdb_tag)
      |=> ent_rdy1[e]);

    assert_wake_src2_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && ent_busy[e] && !ent_gnt[e] && !ent_kill[e] && ent_src2[e] == cdb_tag)
      |=> ent_rdy2[e]);

    assert_ready_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_busy[e] && ent_rdy1[e] && ent_rdy2[e] && !ent_gnt[e] && !ent_kill[e])
      |=> (ent_busy[e] && ent_rdy1[e] && ent_rdy2[e]));

    assert_issue_only_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ent_gnt[e] |-> (ent_busy[e] && ent_rdy1[e] && ent_rdy2[e]));

    assert_issue_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ent_gnt[e] |=> !ent_busy[e]);

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ent_kill[e] |=> !ent_busy[e]);
  end

  for (genvar c = 0; c < NUM_FU; c++) begin : g_cls
    assert_single_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[c] |-> ($countones(ent_gnt[c*SLOTS +: SLOTS]) == 1));

    assert_no_dst_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid[c] && !iss_has_dst[c]) |-> (iss_dst[c] == '0));
  end
endmodule

bind rs_pool rs_pool_chk #(.NUM_FU(NUM_FU), .SLOTS(SLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cdb_valid   (cdb_valid),
  .cdb_tag     (cdb_tag),
  .disp_valid  (disp_valid),
  .disp_stall  (disp_stall),
  .ent_busy    (ent_busy),
  .ent_gnt     (ent_gnt),
  .ent_kill    (ent_kill),
  .ent_wr      (ent_wr),
  .ent_rdy1    (ent_rdy1),
  .ent_rdy2    (ent_rdy2),
  .ent_src1    (ent_src1),
  .ent_src2    (ent_src2),
  .iss_valid   (iss_valid),
  .iss_has_dst (iss_has_dst),
  .iss_dst     (iss_dst)
);

// File: tb/rs_pool_test.sv
`timescale 1ns/1ps
module rs_pool_test;
  import rs_pkg::*;

  localparam int NUM_FU = 4;
  localparam int SLOTS  = 2;
  localparam int FU_W   = 2;

  logic                          clk = 1'b0;
  logic                          rst_n;
  logic                          disp_valid;
  logic [FU_W-1:0]               disp_fu;
  logic [OP_W-1:0]               disp_op;
  logic                          disp_has_dst;
  logic [TAG_W-1:0]              disp_dst, disp_src1, disp_src2;
  logic                          disp_src1_rdy, disp_src2_rdy;
  logic [ROB_W-1:0]              disp_rob;
  logic                          disp_stall;
  logic                          cdb_valid;
  logic [TAG_W-1:0]              cdb_tag;
  logic [ROB_W-1:0]              rob_head;
  logic                          flush_valid;
  logic [ROB_W-1:0]              flush_rob;
  logic [NUM_FU-1:0]             iss_valid;
  logic [NUM_FU-1:0][OP_W-1:0]   iss_op;
  logic [NUM_FU-1:0]             iss_has_dst;
  logic [NUM_FU-1:0][TAG_W-1:0]  iss_dst, iss_src1, iss_src2;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rs_pool #(.NUM_FU(NUM_FU), .SLOTS(SLOTS)) uut (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic quiet();
    disp_valid = 0; disp_fu = 0; disp_op = 0; disp_has_dst = 0; disp_dst = 0;
    disp_src1 = 0; disp_src1_rdy = 0; disp_src2 = 0; disp_src2_rdy = 0;
    disp_rob = 0; cdb_valid = 0; cdb_tag = 0; flush_valid = 0; flush_rob = 0;
  endtask

  // advance one cycle: inputs change away from the rising edge
  task automatic next();
    @(negedge clk);
    quiet();
    #1;
  endtask

  task automatic disp(input int fu, input int op, input bit hd, input int dst,
                      input int s1, input bit r1, input int s2, input bit r2,
                      input int rob);
    disp_valid = 1; disp_fu = FU_W'(fu); disp_op = OP_W'(op); disp_has_dst = hd;
    disp_dst = TAG_W'(dst); disp_src1 = TAG_W'(s1); disp_src1_rdy = r1;
    disp_src2 = TAG_W'(s2); disp_src2_rdy = r2; disp_rob = ROB_W'(rob);
  endtask

  task automatic bcast(input int tag);
    cdb_valid = 1; cdb_tag = TAG_W'(tag);
  endtask

  task automatic t_reset();
    quiet(); rob_head = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    check("R1", "iss_valid after reset", 32'(iss_valid), 0);
    disp(1, 1, 1, 1, 1, 0, 2, 0, 0); #1;
    check("R1", "stall on empty pool", 32'(disp_stall), 0);
    quiet();
    next();
  endtask

  task automatic t_ready_at_dispatch();
    disp(0, 3, 1, 10, 1, 1, 2, 1, 0); #1;
    check("R2", "no stall with free slot", 32'(disp_stall), 0);
    next();
    check("R3", "ready-at-dispatch issues", 32'(iss_valid[0]), 1);
    check("R6", "issued op", 32'(iss_op[0]), 3);
    check("R6", "issued dst", 32'(iss_dst[0]), 10);
    check("R6", "issued src1", 32'(iss_src1[0]), 1);
    check("R6", "issued src2", 32'(iss_src2[0]), 2);
    next();
    check("R7", "freed after issue", 32'(iss_valid[0]), 0);
  endtask

  task automatic t_broadcast_wakeup();
    disp(1, 5, 1, 20, 11, 0, 12, 0, 1);
    next();
    disp(1, 6, 1, 21, 11, 0, 13, 1, 2);
    next();
    check("R3", "not-ready sources wait", 32'(iss_valid[1]), 0);
    bcast(30);
    next();
    check("R4", "unrelated tag no wake", 32'(iss_valid[1]), 0);
    bcast(11);
    next();
    check("R4", "tag 11 wakes slot1 entry", 32'(iss_valid[1]), 1);
    check("R4", "slot1 op", 32'(iss_op[1]), 6);
    bcast(12);
    next();
    check("R4", "second source wakes slot0", 32'(iss_valid[1]), 1);
    check("R4", "slot0 op", 32'(iss_op[1]), 5);
    check("R4", "slot0 dst", 32'(iss_dst[1]), 20);
    next();
    check("R7", "class 1 empty", 32'(iss_valid[1]), 0);
  endtask

  task automatic t_invalid_broadcast();
    disp(2, 7, 1, 22, 40, 0, 41, 1, 3);
    next();
    cdb_valid = 0; cdb_tag = 40;
    next();
    check("R4", "tag ignored while cdb_valid=0", 32'(iss_valid[2]), 0);
    bcast(40);
    next();
    check("R4", "valid broadcast wakes", 32'(iss_valid[2]), 1);
    next();
  endtask

  task automatic t_same_cycle_bypass();
    disp(3, 9, 1, 23, 50, 0, 51, 1, 4);
    bcast(50);
    next();
    check("R5", "broadcast during dispatch marks source", 32'(iss_valid[3]), 1);
    check("R5", "bypassed op", 32'(iss_op[3]), 9);
    next();
  endtask

  task automatic t_stall_and_priority();
    disp(0, 7, 1, 24, 60, 0, 61, 1, 4);
    next();
    disp(0, 8, 1, 25, 60, 0, 61, 1, 5);
    next();
    disp(0, 9, 1, 26, 60, 0, 61, 1, 6); #1;
    check("R2", "full class stalls", 32'(disp_stall), 1);
    disp_fu = 1; #1;
    check("R2", "other class does not stall", 32'(disp_stall), 0);
    disp_valid = 0;
    next();
    bcast(60);
    next();
    check("R6", "lowest slot first", 32'(iss_op[0]), 7);
    next();
    check("R6", "next slot second", 32'(iss_op[0]), 8);
    next();
    check("R2", "stalled dispatch dropped", 32'(iss_valid[0]), 0);
    disp(0, 10, 1, 27, 1, 1, 2, 1, 7); #1;
    check("R7", "freed slot reusable", 32'(disp_stall), 0);
    next();
    check("R7", "reused slot issues", 32'(iss_op[0]), 10);
    next();
  endtask

  task automatic t_store();
    disp(2, 11, 0, 33, 3, 1, 4, 1, 8);
    next();
    check("R8", "store issues", 32'(iss_valid[2]), 1);
    check("R8", "store has no dst", 32'(iss_has_dst[2]), 0);
    check("R8", "store dst zero", 32'(iss_dst[2]), 0);
    next();
  endtask

  task automatic t_flush(input int head, input int rob_old, input int rob_young,
                         input int tgt, input int tag);
    rob_head = ROB_W'(head);
    disp(1, 13, 1, 40, tag, 0, 5, 1, rob_old);
    next();
    disp(1, 14, 1, 41, tag, 0, 5, 1, rob_young);
    next();
    flush_valid = 1; flush_rob = ROB_W'(tgt);
    next();
    bcast(tag);
    next();
    check("R9", "older entry survives", 32'(iss_valid[1]), 1);
    check("R9", "survivor op", 32'(iss_op[1]), 13);
    next();
    check("R9", "younger entry removed", 32'(iss_valid[1]), 0);
    rob_head = 0;
  endtask

  task automatic t_flush_vs_dispatch();
    disp(3, 15, 1, 42, 1, 1, 2, 1, 1);
    flush_valid = 1; flush_rob = 7;
    next();
    check("R10", "dispatch dropped during flush", 32'(iss_valid[3]), 0);
    next();
  endtask

  task automatic t_flush_vs_issue();
    disp(0, 16, 1, 43, 1, 1, 2, 1, 6);
    next();
    flush_valid = 1; flush_rob = 4; #1;
    check("R9", "flushed entry not issued", 32'(iss_valid[0]), 0);
    next();
    check("R9", "flushed entry gone", 32'(iss_valid[0]), 0);
  endtask

  task automatic t_parallel_classes();
    disp(0, 17, 1, 44, 80, 0, 2, 1, 1);
    next();
    disp(1, 18, 1, 45, 80, 0, 2, 1, 2);
    bcast(80);
    next();
    check("R4", "one broadcast wakes two classes", 32'(iss_valid[1:0]), 3);
    check("R6", "class 0 op", 32'(iss_op[0]), 17);
    check("R6", "class 1 op", 32'(iss_op[1]), 18);
    next();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_ready_at_dispatch();
    t_broadcast_wakeup();
    t_invalid_broadcast();
    t_same_cycle_bypass();
    t_stall_and_priority();
    t_store();
    t_flush(0, 2, 5, 3, 70);
    t_flush(14, 15, 1, 0, 71);
    t_flush_vs_dispatch();
    t_flush_vs_issue();
    t_parallel_classes();
    summary();
    $finish;
  end
endmodule